// File: doc/BRIEF.md
# Synthesizer Power-Down Sequencer

This block decides whether a frequency-synthesizer core is running or powered down. The decision comes from a chip-enable input and two configuration bits: a power-down request bit and a charge-pump tristate bit. The block drives four enables, one each for the reference oscillator buffer, the RF prescaler, the phase/frequency detector and the charge pump. It also drives a hold signal that keeps the reference and feedback dividers at their load point, and a request to put the analog pins into high impedance.

Power-down comes in two flavours. The asynchronous kind, from chip enable low or from both bits set, shuts the core off in the same cycle. The synchronous kind, with the request bit set and the tristate bit clear, waits for the charge pump to report a completed pulse, so no correction pulse is cut short. On wake-up the analog circuits turn on at once. The dividers stay held for a settling delay that is derived from the clock frequency and the delay in nanoseconds, and then they are released together.

Top module: `synth_pwr_ctrl`

## Requirements
- R1: While `chip_en` is 0, all four analog enables are 0 and `div_hold` and `pins_hiz` are 1 in that same cycle, whatever the two configuration bits hold.
- R2: With `chip_en`=1 and `cfg_pwrdn`=0 the command is normal operation, and a powered-down block returns to running through the settling delay.
- R3: With `chip_en`=1, `cfg_pwrdn`=1 and `cfg_cp_tri`=0 while running, the enables stay 1 until a cycle in which `cp_pulse_done`=1 is sampled. From the following cycle on, the block is powered down.
- R4: With `chip_en`=1, `cfg_pwrdn`=1 and `cfg_cp_tri`=1, the enables drop to 0 and `div_hold` and `pins_hiz` rise in the same cycle, without waiting for a pulse.
- R5: While powered down, all four enables are 0, `pins_hiz` is 1 and `div_hold` is 1. The four enables always share one value, and `pins_hiz` is its inverse.
- R6: After the first clock edge that samples a normal command while powered down, the enables are 1 at once. `div_hold` stays 1 for exactly SETTLE_CYC cycles and then falls.
- R7: SETTLE_CYC equals ceil(CLK_KHZ*SETTLE_NS/1,000,000) clock cycles, with a minimum of 1.
- R8: Any power-down command during the settling delay returns the block to power-down. The next normal command restarts the full delay.
- R9: A synchronous request that is withdrawn before any `cp_pulse_done` is sampled leaves the block running, with no cycle of disabled outputs.
- R10: `run_ok` is 1 exactly when the enables are 1, `div_hold` is 0 and the command is normal operation.
- R11: During and just after reset the block is powered down (enables 0, `div_hold` 1, `pins_hiz` 1, `run_ok` 0). A normal command then passes through the full settling delay.
- R12: `cp_pulse_done` has no effect unless a synchronous power-down command is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| chip_en | input | 1 | Chip enable; 0 forces immediate power-down |
| cfg_pwrdn | input | 1 | Programmed power-down request bit |
| cfg_cp_tri | input | 1 | Programmed charge-pump tristate bit; selects immediate (1) or pulse-gated (0) power-down |
| cp_pulse_done | input | 1 | Strobe: a charge-pump pulse has just completed |
| osc_en | output | 1 | Reference oscillator buffer enable |
| presc_en | output | 1 | RF prescaler enable |
| pfd_en | output | 1 | Phase/frequency detector enable |
| cp_en | output | 1 | Charge pump enable |
| div_hold | output | 1 | Hold reference and feedback dividers at their load point |
| pins_hiz | output | 1 | Request high impedance on analog pins |
| run_ok | output | 1 | Fully in normal operation with dividers released |

## Verification
The bench builds the block with CLK_KHZ=10000 and SETTLE_NS=800, which gives a settling window of 8 cycles. A window that short lets every wake-up run to completion many times within the run. It also lets a power-down command land at each position inside the window, from its first cycle to its last. Pulse strobes arrive at a low random rate, so synchronous requests are seen both withdrawn before any pulse and taken on a pulse that coincides with the request cycle.

// File: rtl/synth_pwr_pkg.sv
package synth_pwr_pkg;

  typedef enum logic [1:0] {
    CMD_NORMAL = 2'd0,
    CMD_SYNC   = 2'd1,
    CMD_ASYNC  = 2'd2
  } pd_cmd_t;

  typedef enum logic [1:0] {
    ST_DOWN      = 2'd0,
    ST_SETTLE    = 2'd1,
    ST_RUN       = 2'd2,
    ST_SYNC_WAIT = 2'd3
  } pd_state_t;

  // Settling window in clocks: ceil(kHz * ns / 1e6), never below one.
  function automatic int unsigned settle_cycles(input int unsigned clk_khz,
                                                input int unsigned delay_ns);
    longint unsigned prod;
    longint unsigned q;
    prod = longint'(clk_khz) * longint'(delay_ns);
    q    = (prod + 64'd999_999) / 64'd1_000_000;
    if (q < 64'd1) q = 64'd1;
    return int'(q);
  endfunction

  // Chip enable low, or both bits set: immediate. Request bit alone: pulse-gated.
  function automatic pd_cmd_t decode_cmd(input logic ce, input logic pwrdn,
                                         input logic cp_tri);
    if (!ce)             return CMD_ASYNC;
    else if (!pwrdn)     return CMD_NORMAL;
    else if (cp_tri)     return CMD_ASYNC;
    else                 return CMD_SYNC;
  endfunction

endpackage

// File: rtl/pwr_cmd_decode.sv
module pwr_cmd_decode
  import synth_pwr_pkg::*;
(
  input  logic    chip_en,
  input  logic    cfg_pwrdn,
  input  logic    cfg_cp_tri,
  output pd_cmd_t cmd
);

  always_comb cmd = decode_cmd(chip_en, cfg_pwrdn, cfg_cp_tri);

endmodule

// File: rtl/pwr_settle_timer.sv
module pwr_settle_timer #(
  parameter int unsigned SETTLE_CYC = 75
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  output logic expire
);

  localparam int unsigned CW = (SETTLE_CYC < 2) ? 1 : $clog2(SETTLE_CYC + 1);

  generate
    if (SETTLE_CYC <= 1) begin : g_single
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign expire = active;
    end else begin : g_count
      logic [CW-1:0] cnt;
      assign expire = active && (cnt == CW'(SETTLE_CYC - 1));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 cnt <= '0;
        else if (!active || expire) cnt <= '0;
        else                        cnt <= cnt + 1'b1;
      end
    end
  endgenerate

endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
  import synth_pwr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  pd_cmd_t   cmd,
  input  logic      cp_pulse_done,
  input  logic      settle_expire,
  output pd_state_t state
);

  pd_state_t nxt;
  logic      go_down;

  // Leaving a running state: at once for async, on a pulse for sync.
  assign go_down = (cmd == CMD_ASYNC) || ((cmd == CMD_SYNC) && cp_pulse_done);

  always_comb begin
    nxt = state;
    unique case (state)
      ST_DOWN:   if (cmd == CMD_NORMAL) nxt = ST_SETTLE;
      ST_SETTLE: begin
        if (cmd != CMD_NORMAL)   nxt = ST_DOWN;
        else if (settle_expire)  nxt = ST_RUN;
      end
      ST_RUN, ST_SYNC_WAIT: begin
        if (go_down)                nxt = ST_DOWN;
        else if (cmd == CMD_SYNC)   nxt = ST_SYNC_WAIT;
        else                        nxt = ST_RUN;
      end
      default:   nxt = ST_DOWN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_DOWN;
    else        state <= nxt;
  end

endmodule

// File: rtl/synth_pwr_ctrl.sv
module synth_pwr_ctrl
  import synth_pwr_pkg::*;
#(
  parameter int unsigned CLK_KHZ   = 50000,
  parameter int unsigned SETTLE_NS = 1500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic chip_en,
  input  logic cfg_pwrdn,
  input  logic cfg_cp_tri,
  input  logic cp_pulse_done,
  output logic osc_en,
  output logic presc_en,
  output logic pfd_en,
  output logic cp_en,
  output logic div_hold,
  output logic pins_hiz,
  output logic run_ok
);

  localparam int unsigned SETTLE_CYC = settle_cycles(CLK_KHZ, SETTLE_NS);

  pd_cmd_t   cmd;
  pd_state_t state;
  logic      settle_active;
  logic      settle_expire;
  logic      async_now;
  logic      analog_on;
  logic      dividers_live;

  pwr_cmd_decode u_dec (
    .chip_en    (chip_en),
    .cfg_pwrdn  (cfg_pwrdn),
    .cfg_cp_tri (cfg_cp_tri),
    .cmd        (cmd)
  );

  assign settle_active = (state == ST_SETTLE);

  pwr_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (settle_active),
    .expire (settle_expire)
  );

  pwr_seq_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd           (cmd),
    .cp_pulse_done (cp_pulse_done),
    .settle_expire (settle_expire),
    .state         (state)
  );

  // An immediate command overrides the registered state in the same cycle.
  assign async_now     = (cmd == CMD_ASYNC);
  assign analog_on     = (state != ST_DOWN) && !async_now;
  assign dividers_live = ((state == ST_RUN) || (state == ST_SYNC_WAIT)) && !async_now;

  assign osc_en   = analog_on;
  assign presc_en = analog_on;
  assign pfd_en   = analog_on;
  assign cp_en    = analog_on;
  assign pins_hiz = !analog_on;
  assign div_hold = !dividers_live;
  assign run_ok   = dividers_live && (cmd == CMD_NORMAL);

endmodule

// File: rtl/synth_pwr_ctrl_chk.sv
module synth_pwr_ctrl_chk
  import synth_pwr_pkg::*;
#(
  parameter int unsigned CLK_KHZ   = 50000,
  parameter int unsigned SETTLE_NS = 1500
) (
  input logic clk,
  input logic rst_n,
  input logic chip_en,
  input logic cfg_pwrdn,
  input logic cfg_cp_tri,
  input logic cp_pulse_done,
  input logic osc_en,
  input logic presc_en,
  input logic pfd_en,
  input logic cp_en,
  input logic div_hold,
  input logic pins_hiz,
  input logic run_ok
);

  localparam int unsigned WIN = settle_cycles(CLK_KHZ, SETTLE_NS);

  int unsigned held_on_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  held_on_cnt <= 0;
    else if (cp_en && div_hold)  held_on_cnt <= held_on_cnt + 1;
    else                         held_on_cnt <= 0;
  end

  AST_CE_LOW_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !chip_en |-> (!osc_en && !cp_en && div_hold && pins_hiz)); // R1

  AST_ASYNC_BITS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_en && cfg_pwrdn && cfg_cp_tri) |-> (!presc_en && !pfd_en && div_hold && pins_hiz)); // R4

  AST_SYNC_DEFER: assert property (@(posedge clk) disable iff (!rst_n)
    (cp_en && !div_hold && chip_en && cfg_pwrdn && !cfg_cp_tri && !cp_pulse_done)
      |=> (cp_en || !chip_en || cfg_cp_tri)); // R3

  AST_SYNC_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (cp_en && !div_hold && chip_en && cfg_pwrdn && !cfg_cp_tri && cp_pulse_done)
      |=> (!cp_en && div_hold)); // R3

  AST_HIZ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    pins_hiz |-> div_hold); // R5

  AST_SETTLE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (cp_en && !div_hold && $past(div_hold)) |-> (held_on_cnt == WIN)); // R6

  AST_RUN_OK_MEANS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    run_ok |-> (cp_en && !div_hold && chip_en && !cfg_pwrdn)); // R10

  AST_NORMAL_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (cp_en && !div_hold && chip_en && !cfg_pwrdn) |-> run_ok); // R10

endmodule

bind synth_pwr_ctrl synth_pwr_ctrl_chk #(
  .CLK_KHZ   (CLK_KHZ),
  .SETTLE_NS (SETTLE_NS)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .chip_en       (chip_en),
  .cfg_pwrdn     (cfg_pwrdn),
  .cfg_cp_tri    (cfg_cp_tri),
  .cp_pulse_done (cp_pulse_done),
  .osc_en        (osc_en),
  .presc_en      (presc_en),
  .pfd_en        (pfd_en),
  .cp_en         (cp_en),
  .div_hold      (div_hold),
  .pins_hiz      (pins_hiz),
  .run_ok        (run_ok)
);

// File: tb/synth_pwr_ctrl_bench.sv
`timescale 1ns/1ps
module synth_pwr_ctrl_bench;

  localparam int unsigned TB_KHZ = 10000;
  localparam int unsigned TB_NS  = 800;
  // Bench's own rounding: whole clocks, rounded up when a remainder is left.
  localparam int unsigned EXP_WIN =
    ((TB_KHZ * TB_NS) / 1000000) + (((TB_KHZ * TB_NS) % 1000000) != 0 ? 1 : 0);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic chip_en = 1'b0, cfg_pwrdn = 1'b0, cfg_cp_tri = 1'b0, cp_pulse_done = 1'b0;
  logic osc_en, presc_en, pfd_en, cp_en, div_hold, pins_hiz, run_ok;

  int checks = 0;
  int errors = 0;
  string cur_req = "R11";
  bit finished = 1'b0;

  always #10 clk = ~clk;

  synth_pwr_ctrl #(.CLK_KHZ(TB_KHZ), .SETTLE_NS(TB_NS)) u_synth_pwr_ctrl (
    .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .cfg_pwrdn(cfg_pwrdn),
    .cfg_cp_tri(cfg_cp_tri), .cp_pulse_done(cp_pulse_done),
    .osc_en(osc_en), .presc_en(presc_en), .pfd_en(pfd_en), .cp_en(cp_en),
    .div_hold(div_hold), .pins_hiz(pins_hiz), .run_ok(run_ok)
  );

  // Requirement model: powered-down flag and remaining settle clocks.
  bit m_down = 1'b1;
  int m_left = 0;

  function automatic bit is_imm(input logic ce, input logic pd, input logic ct);
    return !ce || (pd && ct);
  endfunction
  function automatic bit is_gated(input logic ce, input logic pd, input logic ct);
    return ce && pd && !ct;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_down = 1'b1; m_left = 0;
    end else begin
      bit normal;
      normal = chip_en && !cfg_pwrdn;
      if (m_down) begin
        if (normal) begin m_down = 1'b0; m_left = EXP_WIN; end
      end else if (m_left > 0) begin
        if (!normal) begin m_down = 1'b1; m_left = 0; end
        else m_left = m_left - 1;
      end else if (is_imm(chip_en, cfg_pwrdn, cfg_cp_tri) ||
                   (is_gated(chip_en, cfg_pwrdn, cfg_cp_tri) && cp_pulse_done)) begin
        m_down = 1'b1;
      end
    end
  end

  function automatic logic [6:0] expected();
    bit imm, on, hold, ok;
    imm  = is_imm(chip_en, cfg_pwrdn, cfg_cp_tri);
    on   = !m_down && !imm;
    hold = m_down || (m_left > 0) || imm;
    ok   = !hold && chip_en && !cfg_pwrdn;
    return {on, on, on, on, hold, !on, ok};
  endfunction

  task automatic compare();
    logic [6:0] act, exp;
    act = {osc_en, presc_en, pfd_en, cp_en, div_hold, pins_hiz, run_ok};
    exp = expected();
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s t=%0t act=%b exp=%b (osc,presc,pfd,cp,hold,hiz,ok)",
               cur_req, $time, act, exp);
    end
  endtask

  task automatic step(input logic ce, input logic pd, input logic ct, input logic done);
    @(negedge clk);
    chip_en = ce; cfg_pwrdn = pd; cfg_cp_tri = ct; cp_pulse_done = done;
    #1;
    compare();
  endtask

  task automatic run_normal(input int n);
    for (int i = 0; i < n; i++) step(1'b1, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    // R11: reset state, even with a normal command presented
    cur_req = "R11";
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b0, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    // R6 R7 R2: wake from reset, hold for exactly EXP_WIN clocks
    cur_req = "R6 R7 R2";
    run_normal(EXP_WIN + 4);
    // R12: pulses with a normal command change nothing
    cur_req = "R12";
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 1'b0, 1'b1);
    // R3: gated power-down waits for the pulse
    cur_req = "R3";
    for (int i = 0; i < 4; i++) step(1'b1, 1'b1, 1'b0, 1'b0);
    step(1'b1, 1'b1, 1'b0, 1'b1);
    cur_req = "R5";
    for (int i = 0; i < 4; i++) step(1'b1, 1'b1, 1'b0, 1'b0);
    cur_req = "R2 R6";
    run_normal(EXP_WIN + 3);
    // R9: withdrawn gated request never interrupts running
    cur_req = "R9";
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 1'b0, i[0]);
    // R4: immediate power-down by both bits
    cur_req = "R4";
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 1'b1, 1'b0);
    // R8: interrupt the settle window, then full restart
    cur_req = "R8";
    run_normal(3);
    step(1'b1, 1'b1, 1'b0, 1'b1);
    run_normal(EXP_WIN + 2);
    // R1: chip enable low overrides everything
    cur_req = "R1";
    step(1'b0, 1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b1, 1'b0, 1'b1);
    run_normal(EXP_WIN + 2);
    // Random mix
    cur_req = "R5 R10";
    for (int i = 0; i < 4000; i++) begin
      logic ce, pd, ct, dn;
      ce = ($urandom_range(0, 19) != 0);
      pd = ($urandom_range(0, 5) == 0);
      ct = $urandom_range(0, 1);
      dn = ($urandom_range(0, 4) == 0);
      step(ce, pd, ct, dn);
    end
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule